// File: doc/BRIEF.md
# Shared Buffer Admission and Pause Control

This block keeps a count, per ingress port, of the 128-byte buffers that port currently holds in a shared packet memory. Each cycle, any port may request one new buffer, release one buffer, or do both. The block decides whether the request is granted or the frame must be dropped. It also raises a per-port pause request, which the MAC turns into pause frames or backpressure.

A port counts as active once it holds 36 or more buffers. When at most one port is active, the generous threshold set applies. When two or more ports are active, the tighter set applies. Each set holds a drop limit and a pause level, and all four values are 8-bit configuration inputs. The active-port count is worked out again every cycle from the registered occupancies. Pause is held with a fixed hysteresis of four buffers.

Top module: `shared_buf_adm`

## Requirements
- R1: During and after reset every occupancy is zero, and admit_o, drop_o, pause_o and free_err_o are all low.
- R2: An allocation request on a port whose occupancy is below the selected drop limit is granted. admit_o for that port is high in the cycle after the request, and the occupancy grows by one.
- R3: An allocation request on a port whose occupancy is at or above the selected drop limit is refused. drop_o is high in the cycle after the request, and the refusal leaves the occupancy unchanged.
- R4: A port is active when its occupancy is 36 or more. With zero or one active port, drop_hi_i and pause_hi_i are selected. With two or three active ports, drop_lo_i and pause_lo_i are selected.
- R5: pause_o for a port goes high one cycle after its occupancy is at or above the selected pause level.
- R6: Once raised, pause_o stays high until the occupancy plus 4 is below the selected pause level. It is cleared one cycle after that holds.
- R7: A granted allocation and a free on the same port in the same cycle leave that port's occupancy unchanged.
- R8: A free on a port at occupancy zero, without a granted allocation in the same cycle, is ignored. free_err_o is high in the next cycle.
- R9: A free on its own at a nonzero occupancy lowers that occupancy by one.
- R10: Ports are counted independently. They interact only through the active-port count that selects the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | NP | Per-port request for one buffer |
| free_i | input | NP | Per-port release of one buffer |
| drop_hi_i | input | 8 | Drop limit when at most one port is active |
| drop_lo_i | input | 8 | Drop limit when two or more ports are active |
| pause_hi_i | input | 8 | Pause level when at most one port is active |
| pause_lo_i | input | 8 | Pause level when two or more ports are active |
| admit_o | output | NP | Request of the previous cycle was granted |
| drop_o | output | NP | Request of the previous cycle was refused |
| pause_o | output | NP | Pause or backpressure request |
| free_err_o | output | NP | Free of the previous cycle hit an empty port |

## Verification
admit_o, drop_o and free_err_o are due exactly one cycle after the request or free that causes them. Each is judged against the model's occupancy and the model's threshold selection as they stood before that clock edge. pause_o is one register behind the occupancy, so the bench model computes the next pause state from the occupancy before the update. The bench drives inputs on the falling edge and compares every output on the next falling edge, so each check lands in the cycle where the result first appears.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int unsigned LVL_W = 8;

  typedef struct packed {
    logic [LVL_W-1:0] drop_lim;
    logic [LVL_W-1:0] pause_lim;
  } lim_t;
endpackage

// File: rtl/sba_level_sel.sv
module sba_level_sel
  import sba_pkg::*;
#(
  parameter int unsigned NP      = 3,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ACT_THR = 36,
  parameter int unsigned MULTI   = 2
) (
  input  logic [NP-1:0][CNT_W-1:0] occ_i,
  input  logic [LVL_W-1:0]         drop_hi_i,
  input  logic [LVL_W-1:0]         drop_lo_i,
  input  logic [LVL_W-1:0]         pause_hi_i,
  input  logic [LVL_W-1:0]         pause_lo_i,
  output lim_t                     lim_o
);
  localparam int unsigned NA_W = $clog2(NP + 1);

  logic [NP-1:0] act;
  logic [NA_W-1:0] n_act;

  for (genvar p = 0; p < NP; p++) begin : g_act
    assign act[p] = (occ_i[p] >= CNT_W'(ACT_THR));
  end

  always_comb begin
    n_act = '0;
    for (int p = 0; p < NP; p++) n_act = n_act + NA_W'(act[p]);
  end

  always_comb begin
    if (n_act >= NA_W'(MULTI)) begin
      lim_o.drop_lim  = drop_lo_i;
      lim_o.pause_lim = pause_lo_i;
    end else begin
      lim_o.drop_lim  = drop_hi_i;
      lim_o.pause_lim = pause_hi_i;
    end
  end
endmodule

// File: rtl/sba_port_cnt.sv
module sba_port_cnt
  import sba_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_i,
  input  logic             free_i,
  input  logic [LVL_W-1:0] drop_lim_i,
  output logic [CNT_W-1:0] occ_o,
  output logic             admit_o,
  output logic             drop_o,
  output logic             err_o
);
  logic [CNT_W-1:0] occ_q, occ_d;
  logic grant, empty;

  assign empty = (occ_q == '0);
  assign grant = alloc_i && ({1'b0, occ_q} < (CNT_W+1)'(drop_lim_i));

  always_comb begin
    occ_d = occ_q;
    if (grant && !free_i)       occ_d = occ_q + 1'b1;
    else if (!grant && free_i && !empty) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= '0;
      admit_o <= 1'b0;
      drop_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      occ_q   <= occ_d;
      admit_o <= grant;
      drop_o  <= alloc_i && !grant;
      err_o   <= free_i && !grant && empty;
    end
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/sba_pause.sv
module sba_pause
  import sba_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned HYST  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_i,
  input  logic [LVL_W-1:0] pause_lim_i,
  output logic             pause_o
);
  localparam int unsigned W = (CNT_W > LVL_W ? CNT_W : LVL_W) + 2;

  logic set_c, clr_c;
  assign set_c = W'(occ_i) >= W'(pause_lim_i);
  assign clr_c = (W'(occ_i) + W'(HYST)) < W'(pause_lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pause_o <= 1'b0;
    else if (set_c) pause_o <= 1'b1;
    else if (clr_c) pause_o <= 1'b0;
  end
endmodule

// File: rtl/shared_buf_adm.sv
module shared_buf_adm
  import sba_pkg::*;
#(
  parameter int unsigned NP      = 3,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned ACT_THR = 36,
  parameter int unsigned HYST    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NP-1:0]    alloc_req_i,
  input  logic [NP-1:0]    free_i,
  input  logic [LVL_W-1:0] drop_hi_i,
  input  logic [LVL_W-1:0] drop_lo_i,
  input  logic [LVL_W-1:0] pause_hi_i,
  input  logic [LVL_W-1:0] pause_lo_i,
  output logic [NP-1:0]    admit_o,
  output logic [NP-1:0]    drop_o,
  output logic [NP-1:0]    pause_o,
  output logic [NP-1:0]    free_err_o
);
  logic [NP-1:0][CNT_W-1:0] occ;
  lim_t lim;

  sba_level_sel #(.NP(NP), .CNT_W(CNT_W), .ACT_THR(ACT_THR), .MULTI(2)) u_sel (
    .occ_i     (occ),
    .drop_hi_i (drop_hi_i),
    .drop_lo_i (drop_lo_i),
    .pause_hi_i(pause_hi_i),
    .pause_lo_i(pause_lo_i),
    .lim_o     (lim)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    sba_port_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .alloc_i   (alloc_req_i[p]),
      .free_i    (free_i[p]),
      .drop_lim_i(lim.drop_lim),
      .occ_o     (occ[p]),
      .admit_o   (admit_o[p]),
      .drop_o    (drop_o[p]),
      .err_o     (free_err_o[p])
    );

    sba_pause #(.CNT_W(CNT_W), .HYST(HYST)) u_pause (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .occ_i      (occ[p]),
      .pause_lim_i(lim.pause_lim),
      .pause_o    (pause_o[p])
    );
  end
endmodule

// File: rtl/sba_chk.sv
module sba_chk
  import sba_pkg::*;
#(
  parameter int unsigned NP    = 3,
  parameter int unsigned CNT_W = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NP-1:0]            alloc_i,
  input logic [NP-1:0]            free_i,
  input logic [LVL_W-1:0]         pause_hi_i,
  input logic [LVL_W-1:0]         pause_lo_i,
  input logic [NP-1:0]            admit_i,
  input logic [NP-1:0]            drop_i,
  input logic [NP-1:0]            pause_i,
  input logic [NP-1:0]            err_i,
  input logic [NP-1:0][CNT_W-1:0] occ_i
);
  logic [LVL_W-1:0] pause_min;
  assign pause_min = (pause_hi_i < pause_lo_i) ? pause_hi_i : pause_lo_i;

  // R2 R3
  admit_drop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (admit_i & drop_i) == '0);

  // R2
  admit_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (admit_i & ~$past(alloc_i)) == '0);

  // R8
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_i & ~$past(free_i)) == '0);

  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R3
    drop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drop_i[p] && !$past(free_i[p])) |-> occ_i[p] == $past(occ_i[p]));

    // R7
    occ_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (occ_i[p] == $past(occ_i[p])) || (occ_i[p] == $past(occ_i[p]) + 1'b1) ||
      (occ_i[p] == $past(occ_i[p]) - 1'b1));

    // R5
    pause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pause_i[p]) |-> ($past(occ_i[p]) >= CNT_W'(pause_min)));
  end
endmodule

bind shared_buf_adm sba_chk #(.NP(NP), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .alloc_i   (alloc_req_i),
  .free_i    (free_i),
  .pause_hi_i(pause_hi_i),
  .pause_lo_i(pause_lo_i),
  .admit_i   (admit_o),
  .drop_i    (drop_o),
  .pause_i   (pause_o),
  .err_i     (free_err_o),
  .occ_i     (occ)
);

// File: tb/shared_buf_adm_tb.sv
module shared_buf_adm_tb;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0] alloc, fr;
  logic [7:0] drop_hi, drop_lo, pause_hi, pause_lo;
  logic [NP-1:0] admit, drop, pause, ferr;

  always #5 clk = ~clk;

  shared_buf_adm u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_req_i(alloc), .free_i(fr),
    .drop_hi_i(drop_hi), .drop_lo_i(drop_lo), .pause_hi_i(pause_hi), .pause_lo_i(pause_lo),
    .admit_o(admit), .drop_o(drop), .pause_o(pause), .free_err_o(ferr)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_occ [NP];
  int adm_cnt [NP];
  logic [NP-1:0] e_adm, e_drp, e_pau, e_err;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int act_cnt();
    int n = 0;
    for (int p = 0; p < NP; p++) if (m_occ[p] >= 36) n++;
    return n;
  endfunction

  // one cycle: check previous results, drive new inputs, advance the model
  task automatic step(input logic [NP-1:0] a, input logic [NP-1:0] f);
    int dl, pl;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      chk("R2 admit", admit[p], e_adm[p]);
      chk("R3 drop", drop[p], e_drp[p]);
      chk("R5/R6 pause", pause[p], e_pau[p]);
      chk("R8 free_err", ferr[p], e_err[p]);
      if (admit[p]) adm_cnt[p]++;
    end
    alloc = a; fr = f;
    // R4 threshold selection
    dl = (act_cnt() >= 2) ? int'(drop_lo) : int'(drop_hi);
    pl = (act_cnt() >= 2) ? int'(pause_lo) : int'(pause_hi);
    for (int p = 0; p < NP; p++) begin
      logic g;
      if (m_occ[p] >= pl) e_pau[p] = 1'b1;
      else if (m_occ[p] + 4 < pl) e_pau[p] = 1'b0;
      g = a[p] && (m_occ[p] < dl);
      e_adm[p] = g;
      e_drp[p] = a[p] && !g;
      e_err[p] = f[p] && !g && (m_occ[p] == 0);
      if (g && !f[p]) m_occ[p]++;                       // R2
      else if (!g && f[p] && m_occ[p] > 0) m_occ[p]--;  // R9; R7 when g && f
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5ba1));
    alloc = '0; fr = '0;
    drop_hi = 8'd60; drop_lo = 8'd40; pause_hi = 8'd50; pause_lo = 8'd30;
    e_adm = '0; e_drp = '0; e_pau = '0; e_err = '0;
    for (int p = 0; p < NP; p++) begin m_occ[p] = 0; adm_cnt[p] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset admit", admit, 0); chk("R1 reset drop", drop, 0);
    chk("R1 reset pause", pause, 0); chk("R1 reset ferr", ferr, 0);
    rst_ni = 1'b1;
    // R8 free at zero on all ports
    step('0, 3'b111);
    step('0, '0);
    // R4 single active: port 0 alone reaches the high drop limit (R10 others idle)
    for (int i = 0; i < 80; i++) step(3'b001, '0);
    step('0, '0);
    chk("R4 high limit admits", adm_cnt[0], 60);
    chk("R10 idle port count", adm_cnt[1], 0);
    // R7 simultaneous alloc and free on port 1
    step(3'b010, '0); step(3'b010, 3'b010); step('0, '0);
    // R4 two or more active: low limit applies
    for (int p = 0; p < NP; p++) adm_cnt[p] = 0;
    for (int i = 0; i < 80; i++) step(3'b110, '0);
    step('0, '0);
    chk("R4 low limit port1 admits", adm_cnt[1], 39);
    chk("R4 low limit port2 admits", adm_cnt[2], 40);
    // R6 drain all: pause must release
    for (int i = 0; i < 90; i++) step('0, 3'b111);
    step('0, '0);
    chk("R6 pause released", pause, 0);
    // random mix with bursts
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0] a, f;
      int bias = ((i / 300) % 2 == 0) ? 70 : 30;
      for (int p = 0; p < NP; p++) begin
        a[p] = ($urandom % 100) < bias;
        f[p] = ($urandom % 100) < (100 - bias);
      end
      step(a, f);
    end
    step('0, '0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule